// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer

This block is a software watchdog for a small microcontroller. It does not count system clock cycles. It counts single-cycle pulses from a periodic tick that an external divider produces, and it divides those pulses by eight in a small counter of its own. Software must keep the watchdog alive by writing a value with bit 0 cleared to one fixed bus address. If the count of ticks since the last service passes eight, the block raises a reset request for one clock cycle. The CPU reset sequencer then acts on that request.

A service write clears only the block's own divide-by-eight stage. The upstream tick divider keeps running, so the real time to expiry lies between seven and eight tick periods after the last service. The block raises no interrupt. Its service register cannot be read, so the block has no read data path. A configuration input enables the watchdog. While that input is low, the watchdog stays idle.

Top module: `cop_watchdog`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge (synchronous reset), the tick counter goes to 0 and `reset_req` is low. After reset, the first request comes on the eighth tick.
- R2: While enabled, each cycle with `tick` high and no service write advances the counter by one. A cycle without a tick and without a service leaves the counter unchanged. Counting from 0, the eighth tick raises `reset_req`, which is seen in the cycle after the clock edge that samples that tick.
- R3: `reset_req` is high for exactly one clock cycle at a time. The same edge that raises it returns the counter to 0, so the next request needs eight more ticks.
- R4: A service write is `wr_en` high, `wr_addr` equal to 0x07F0 and `wr_data` bit 0 equal to 0. It returns the counter to 0 and no request follows it. Bits 7 to 1 of `wr_data` do not affect it.
- R5: A write to 0x07F0 with `wr_data` bit 0 equal to 1 is not a service. The counter keeps its value.
- R6: A write to any address other than 0x07F0 has no effect on the counter.
- R7: If a service write and a tick arrive in the same cycle, the service wins. The counter becomes 0 and no request is raised, even when the counter stood at 7.
- R8: While `cop_en` is low, the counter is held at 0 and `reset_req` stays low, whatever ticks arrive. When `cop_en` goes high again, counting starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cop_en | input | 1 | Watchdog enable from the configuration option |
| tick | input | 1 | Single-cycle periodic tick pulse, synchronous to `clk` |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 16 | Bus write address |
| wr_data | input | 8 | Bus write data |
| reset_req | output | 1 | One-cycle watchdog reset request |

## Verification
Every result is registered once. The effect of a tick or write on the counter, and any `reset_req` it causes, therefore shows up in the cycle after the edge that samples the stimulus. The bench drives each stimulus on a falling edge and samples `reset_req` on the next falling edge, which is exactly one rising edge later.

The counter is not visible at the ports. After each stimulus, the bench recovers the counter by sending ticks until a request appears and comparing that count with eight minus the expected count. It then checks that the request has dropped one cycle later.

The sweep covers every counter value from 0 to 7. At each value it applies every write kind, each with and without a same-cycle tick.

// File: rtl/cop_wd_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and the counter action type for the tick watchdog.
// Assumes: all watchdog modules import this package.
package cop_wd_pkg;
    localparam int unsigned DEF_DIV_W  = 3;
    localparam int unsigned DEF_ADDR_W = 16;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_SVC_ADDR = 16'h07F0;
    localparam int unsigned DEF_SVC_BIT  = 0;

    // Next-state choice for the divide-by-eight counter
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_CLEAR   = 2'd1,
        ACT_ADVANCE = 2'd2,
        ACT_WRAP    = 2'd3
    } cnt_act_e;
endpackage

// File: rtl/cop_svc_decode.sv
`timescale 1ns/1ps
// Module: cop_svc_decode
// Detects a service write: strobe high, address match, service bit clear.
// Assumes: the write port is sampled by the caller's clock; purely combinational here.
module cop_svc_decode #(
    parameter int unsigned ADDR_W   = cop_wd_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W   = cop_wd_pkg::DEF_DATA_W,
    parameter int unsigned SVC_ADDR = cop_wd_pkg::DEF_SVC_ADDR,
    parameter int unsigned SVC_BIT  = cop_wd_pkg::DEF_SVC_BIT
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              svc_hit
);
    localparam logic [ADDR_W-1:0] MATCH_ADDR = ADDR_W'(SVC_ADDR);

    logic addr_match;
    logic unused_data;

    // Compare the write address with the fixed service location
    always_comb begin
        addr_match = (wr_addr == MATCH_ADDR);
    end

    // A service needs the strobe, the address and a zero in the service bit
    always_comb begin
        svc_hit = wr_en && addr_match && !wr_data[SVC_BIT];
    end

    // The remaining data bits are unimplemented and intentionally unused
    assign unused_data = ^wr_data;
endmodule

// File: rtl/cop_action_sel.sv
`timescale 1ns/1ps
// Module: cop_action_sel
// Chooses the next counter action from enable, service, tick and current count.
// Assumes: service has priority over tick; disable forces a clear.
module cop_action_sel #(
    parameter int unsigned DIV_W = cop_wd_pkg::DEF_DIV_W
) (
    input  logic                 cop_en,
    input  logic                 svc_hit,
    input  logic                 tick,
    input  logic [DIV_W-1:0]     count,
    output cop_wd_pkg::cnt_act_e act
);
    import cop_wd_pkg::*;

    localparam logic [DIV_W-1:0] CNT_LAST = '1;

    logic at_last;

    // Flag the final count before the divider wraps
    always_comb begin
        at_last = (count == CNT_LAST);
    end

    // Priority: disable, then service, then tick (wrap or step), else hold
    always_comb begin
        if (!cop_en) begin
            act = ACT_CLEAR;
        end else if (svc_hit) begin
            act = ACT_CLEAR;
        end else if (tick) begin
            act = at_last ? ACT_WRAP : ACT_ADVANCE;
        end else begin
            act = ACT_HOLD;
        end
    end
endmodule

// File: rtl/cop_tick_div.sv
`timescale 1ns/1ps
// Module: cop_tick_div
// The watchdog's own divide-by-2**DIV_W tick counter.
// Assumes: synchronous active-low reset; act chosen by cop_action_sel.
module cop_tick_div #(
    parameter int unsigned DIV_W = cop_wd_pkg::DEF_DIV_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cop_wd_pkg::cnt_act_e act,
    output logic [DIV_W-1:0]     count
);
    import cop_wd_pkg::*;

    localparam logic [DIV_W-1:0] CNT_ZERO = '0;
    localparam logic [DIV_W-1:0] CNT_ONE  = DIV_W'(1);

    logic [DIV_W-1:0] count_nxt;

    // Next count from the selected action
    always_comb begin
        unique case (act)
            ACT_CLEAR:   count_nxt = CNT_ZERO;
            ACT_WRAP:    count_nxt = CNT_ZERO;
            ACT_ADVANCE: count_nxt = count + CNT_ONE;
            default:     count_nxt = count;
        endcase
    end

    // Counter register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CNT_ZERO;
        end else begin
            count <= count_nxt;
        end
    end
endmodule

// File: rtl/cop_req_gen.sv
`timescale 1ns/1ps
// Module: cop_req_gen
// Registers a one-cycle reset request on the wrap action.
// Assumes: a wrap cannot occur on two consecutive cycles (counter restarts at 0).
module cop_req_gen (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cop_wd_pkg::cnt_act_e act,
    output logic                 reset_req
);
    import cop_wd_pkg::*;

    // Request flop: high for the cycle after a wrap, low otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
        end else begin
            reset_req <= (act == ACT_WRAP);
        end
    end
endmodule

// File: rtl/cop_watchdog.sv
`timescale 1ns/1ps
// Module: cop_watchdog (top)
// Tick-counting watchdog: divides an external periodic tick by 2**DIV_W and
// requests a reset unless software writes a zero service bit at SVC_ADDR.
// Assumes: tick is a one-cycle pulse synchronous to clk; no read path.
module cop_watchdog #(
    parameter int unsigned DIV_W    = cop_wd_pkg::DEF_DIV_W,
    parameter int unsigned ADDR_W   = cop_wd_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W   = cop_wd_pkg::DEF_DATA_W,
    parameter int unsigned SVC_ADDR = cop_wd_pkg::DEF_SVC_ADDR,
    parameter int unsigned SVC_BIT  = cop_wd_pkg::DEF_SVC_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cop_en,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              reset_req
);
    import cop_wd_pkg::*;

    logic             svc_hit;
    logic [DIV_W-1:0] div_count;
    cnt_act_e         div_act;

    // Service write detection
    cop_svc_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SVC_ADDR(SVC_ADDR),
        .SVC_BIT (SVC_BIT)
    ) u_decode (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .svc_hit(svc_hit)
    );

    // Counter action selection
    cop_action_sel #(.DIV_W(DIV_W)) u_sel (
        .cop_en (cop_en),
        .svc_hit(svc_hit),
        .tick   (tick),
        .count  (div_count),
        .act    (div_act)
    );

    // Divide-by-eight tick counter
    cop_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .act  (div_act),
        .count(div_count)
    );

    // One-cycle request output
    cop_req_gen u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (div_act),
        .reset_req(reset_req)
    );
endmodule

// File: rtl/cop_watchdog_chk.sv
`timescale 1ns/1ps
// Module: cop_watchdog_chk
// Property checker for cop_watchdog, attached with bind below.
// Assumes: svc and count are the decoder output and the divider register.
module cop_watchdog_chk #(
    parameter int unsigned DIV_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cop_en,
    input logic             tick,
    input logic             svc,
    input logic [DIV_W-1:0] count,
    input logic             reset_req
);
    localparam logic [DIV_W-1:0] LAST = '1;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R3

    AST_WRAP_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_en && tick && !svc && count == LAST) |=> (reset_req && count == '0)); // R2

    AST_REQ_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(cop_en && tick && !svc && count == LAST) |=> !reset_req); // R3

    AST_TICK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_en && tick && !svc && count != LAST) |=> (count == DIV_W'($past(count) + 1'b1))); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_en && !tick && !svc) |=> $stable(count)); // R2

    AST_SVC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_en && svc) |=> (count == '0 && !reset_req)); // R7

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cop_en |=> (count == '0 && !reset_req)); // R8
endmodule

bind cop_watchdog cop_watchdog_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cop_en   (cop_en),
    .tick     (tick),
    .svc      (svc_hit),
    .count    (div_count),
    .reset_req(reset_req)
);

// File: tb/cop_watchdog_bench.sv
`timescale 1ns/1ps
// Bench for cop_watchdog: sweeps every count with every write kind.
module cop_watchdog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cop_en = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        reset_req;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cop_watchdog u_cop_watchdog (
        .clk(clk), .rst_n(rst_n), .cop_en(cop_en), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .reset_req(reset_req)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one cycle from a falling edge; sample the request one rising edge later
    task automatic apply(input logic t, input logic we, input logic [15:0] a,
                         input logic [7:0] d, output logic req);
        tick = t; wr_en = we; wr_addr = a; wr_data = d;
        @(negedge clk);
        req = reset_req;
        tick = 1'b0; wr_en = 1'b0;
    endtask

    // Recover the hidden count: ticks needed until the request
    task automatic probe(input int exp_n, input string tag);
        int n = 0;
        logic r = 1'b0;
        for (int i = 0; i < 10 && !r; i++) begin
            apply(1'b1, 1'b0, 16'h0, 8'h0, r);
            n++;
        end
        chk(n, exp_n, tag);
        apply(1'b0, 1'b0, 16'h0, 8'h0, r);
        chk(int'(r), 0, "R3 request drops after one cycle");
    endtask

    task automatic service();
        logic r;
        apply(1'b0, 1'b1, 16'h07F0, 8'h00, r);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic r;
        repeat (3) @(negedge clk);
        chk(int'(reset_req), 0, "R1 request low in reset");
        rst_n = 1'b1;
        probe(8, "R1 first request on eighth tick after reset");
        probe(8, "R3 next request needs eight more ticks");

        // Sweep: count k, tick or not, six write kinds
        for (int k = 0; k < 8; k++) begin
            for (int t = 0; t < 2; t++) begin
                for (int kind = 0; kind < 6; kind++) begin
                    logic        we;
                    logic [15:0] a;
                    logic [7:0]  d;
                    bit          svc;
                    int          exp_cnt;
                    int          exp_req;
                    string       tag;
                    service();
                    for (int j = 0; j < k; j++) begin
                        apply(1'b1, 1'b0, 16'h0, 8'h0, r);
                        chk(int'(r), 0, "R2 no request before eighth tick");
                    end
                    we = (kind != 0);
                    case (kind)
                        1: begin a = 16'h07F0; d = 8'h00; end
                        2: begin a = 16'h07F0; d = 8'hFE; end
                        3: begin a = 16'h07F0; d = 8'hFF; end
                        4: begin a = 16'h07F1; d = 8'h00; end
                        5: begin a = 16'h17F0; d = 8'h00; end
                        default: begin a = 16'h0000; d = 8'h00; end
                    endcase
                    svc = (kind == 1 || kind == 2);
                    exp_req = 0;
                    if (svc) exp_cnt = 0;
                    else if (t == 1) begin
                        if (k == 7) begin exp_cnt = 0; exp_req = 1; end
                        else exp_cnt = k + 1;
                    end else exp_cnt = k;
                    if (svc && t == 1) tag = "R7 service beats tick";
                    else if (svc) tag = "R4 service clears count";
                    else if (kind == 3) tag = "R5 bit0 set is no service";
                    else if (kind >= 4) tag = "R6 other address ignored";
                    else tag = "R2 tick counting";
                    apply(t[0], we, a, d, r);
                    chk(int'(r), exp_req, $sformatf("%s req k=%0d t=%0d kind=%0d", tag, k, t, kind));
                    probe(8 - exp_cnt, $sformatf("%s count k=%0d t=%0d kind=%0d", tag, k, t, kind));
                end
            end
        end

        // Disable holds count at zero and suppresses the request
        service();
        for (int j = 0; j < 7; j++) apply(1'b1, 1'b0, 16'h0, 8'h0, r);
        cop_en = 1'b0;
        for (int j = 0; j < 20; j++) begin
            apply(1'b1, 1'b0, 16'h0, 8'h0, r);
            chk(int'(r), 0, "R8 no request while disabled");
        end
        cop_en = 1'b1;
        probe(8, "R8 counting restarts from zero");

        // Mid-run synchronous reset
        for (int j = 0; j < 5; j++) apply(1'b1, 1'b0, 16'h0, 8'h0, r);
        rst_n = 1'b0;
        apply(1'b1, 1'b0, 16'h0, 8'h0, r);
        chk(int'(r), 0, "R1 request low during reset");
        rst_n = 1'b1;
        probe(8, "R1 reset clears count");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule